// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. It has five sources. One is an external pin. The other four are internal event pulses: timer 0 overflow, timer 1 overflow, time-base overflow, and a combined multi-function event. Each source owns a pending flag. The pin first passes through a two-flop synchronizer, then through an edge detector whose mode is set by a 2-bit field. That field can also switch the pin source off.

The core supplies a phase strobe once per instruction cycle. On that strobe the controller checks three things: the global enable is set, the call stack has room, and at least one pending flag has its own enable set. If all hold, it takes the highest-priority request. It then issues a one-cycle call request together with that source's vector address. In the same step it clears that source's flag and the global enable.

Software sets the global enable again on return from a handler. Flags that are still pending are then serviced in priority order, one per strobe.

Top module: `irq_ctrl`

## Requirements
- R1: On a call, `call_vec` follows fixed priority, highest first: pin source (index 0) gives 0x04, timer 0 (index 1) gives 0x08, timer 1 (index 2) gives 0x0C, time base (index 3) gives 0x14, multi-function (index 4) gives 0x18.
- R2: A request is taken only when three conditions hold: `gie` is high, the source's bit in `src_en` is high, and its pending flag is set.
- R3: A request is taken only in a cycle where `phase_stb` is high. `call_req` is high for exactly the following cycle. A flag raised between strobes is served at the next strobe.
- R4: While `stack_full` is high, no call is issued. The flag stays pending and `gie` stays high.
- R5: Taking a request clears that source's pending flag and clears `gie` on the same edge that raises `call_req`.
- R6: `edge_mode` selects the pin trigger: 00 disables the pin source, 01 triggers on a rising edge, 10 on a falling edge, 11 on both edges.
- R7: Pin edges set no flag while `pin_is_input` is low.
- R8: The pin passes through two synchronizer flops. A level change applied before clock edge k shows in `pend[0]` after edge k+2. The flag then holds until it is serviced or cleared.
- R9: A pulse on `flag_clr[i]` clears flag i. `gie_set` raises `gie`, and `gie_clr` lowers it. Acceptance takes precedence over `gie_set`. A new set of a flag takes precedence over its clear.
- R10: A pulse on `evt_in[j]` sets pending flag j+1 on the next edge.
- R11: After reset, `pend`, `gie`, `call_req` and `call_vec` are all zero. `call_vec` is zero in any cycle without a call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_stb | input | 1 | Instruction phase strobe; the only cycle in which a request is taken |
| stack_full | input | 1 | Call stack has no free entry |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| pin_is_input | input | 1 | Pin is configured as an input |
| edge_mode | input | 2 | Pin trigger mode (see R6) |
| evt_in | input | 4 | Internal event pulses: timer 0, timer 1, time base, multi-function |
| src_en | input | 5 | Per-source enables, bit index as in R1 |
| flag_clr | input | 5 | Software clear of pending flags |
| gie_set | input | 1 | Software set of the global enable |
| gie_clr | input | 1 | Software clear of the global enable |
| call_req | output | 1 | One-cycle call request to the core |
| call_vec | output | 8 | Vector address of the call, zero otherwise |
| gie | output | 1 | Global enable state |
| pend | output | 5 | Pending flags |

## Verification
The checker covers the rules that must hold on every cycle:
- a call is preceded by a strobe, an open stack, a set global enable and an enabled pending flag;
- the global enable is low whenever a call is out;
- the vector is legal, and never bypasses an enabled pin request;
- the pin flag only ever sets under a live edge mode with the pin configured as an input.

Other behaviour only the bench's scenarios can show, because it depends on a reference model tracking history:
- the exact three-edge pin latency;
- the rising, falling and both-edges trigger modes;
- draining several pending flags in order across repeated enable/strobe rounds;
- a request held back by a full stack and served after the stack frees;
- the precedence between software set/clear and acceptance.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
    localparam int NSRC  = 5;
    localparam int VEC_W = 8;
    localparam int IDX_W = $clog2(NSRC);

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic [NSRC-1:0]  flags;
        logic             gie;
        logic             call;
        logic [VEC_W-1:0] vec;
    } ctl_state_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        logic [VEC_W-1:0] v;
        case (idx)
            3'd0:    v = 8'h04;
            3'd1:    v = 8'h08;
            3'd2:    v = 8'h0C;
            3'd3:    v = 8'h14;
            3'd4:    v = 8'h18;
            default: v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/irq_edge_det.sv
`timescale 1ns/1ps
module irq_edge_det #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic       pin_is_input,
    input  logic [1:0] mode,
    output logic       hit
);
    // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
    logic [STAGES:0] sh_d, sh_q;
    logic            rise, fall;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin};
        rise = sh_q[STAGES-1] & ~sh_q[STAGES];
        fall = ~sh_q[STAGES-1] & sh_q[STAGES];
        hit  = pin_is_input & ((mode[0] & rise) | (mode[1] & fall));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
    parameter int N     = 5,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        // scan from lowest priority upward so the lowest index wins
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_stb,
    input  logic             stack_full,
    input  logic             ext_pin,
    input  logic             pin_is_input,
    input  logic [1:0]       edge_mode,
    input  logic [NSRC-2:0]  evt_in,
    input  logic [NSRC-1:0]  src_en,
    input  logic [NSRC-1:0]  flag_clr,
    input  logic             gie_set,
    input  logic             gie_clr,
    output logic             call_req,
    output logic [VEC_W-1:0] call_vec,
    output logic             gie,
    output logic [NSRC-1:0]  pend
);
    ctl_state_t       st_d, st_q;
    logic             ext_hit;
    logic [NSRC-1:0]  live_req;
    logic             pick_valid;
    logic [IDX_W-1:0] pick_idx;
    logic             accept;
    logic [NSRC-1:0]  clr_mask;

    irq_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin          (ext_pin),
        .pin_is_input (pin_is_input),
        .mode         (edge_mode),
        .hit          (ext_hit)
    );

    assign live_req = st_q.flags & src_en;

    irq_prio_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
        .req   (live_req),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    always_comb begin
        st_d     = st_q;
        accept   = phase_stb & st_q.gie & ~stack_full & pick_valid;
        clr_mask = accept ? (NSRC'(1) << pick_idx) : '0;

        st_d.flags = (st_q.flags & ~flag_clr & ~clr_mask) | {evt_in, ext_hit};

        if (accept)       st_d.gie = 1'b0;
        else if (gie_set) st_d.gie = 1'b1;
        else if (gie_clr) st_d.gie = 1'b0;

        st_d.call = accept;
        st_d.vec  = accept ? vec_of(pick_idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign call_req = st_q.call;
    assign call_vec = st_q.vec;
    assign gie      = st_q.gie;
    assign pend     = st_q.flags;
endmodule

// File: rtl/irq_ctrl_chk.sv
`timescale 1ns/1ps
module irq_ctrl_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             phase_stb,
    input logic             stack_full,
    input logic             pin_is_input,
    input logic [1:0]       edge_mode,
    input logic [NSRC-1:0]  src_en,
    input logic             call_req,
    input logic [VEC_W-1:0] call_vec,
    input logic             gie,
    input logic [NSRC-1:0]  pend
);
    a_r3_call_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> $past(phase_stb));

    a_r4_no_call_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> !$past(stack_full));

    a_r2_call_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> ($past(gie) && (($past(pend) & $past(src_en)) != '0)));

    a_r5_gie_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> !gie);

    a_r1_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (call_vec == 8'h04 || call_vec == 8'h08 || call_vec == 8'h0C ||
                      call_vec == 8'h14 || call_vec == 8'h18));

    a_r1_pin_first: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && call_vec != 8'h04) |-> !($past(pend[0]) && $past(src_en[0])));

    a_r6_pin_set_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[0]) |-> ($past(edge_mode) != 2'b00 && $past(pin_is_input)));

    a_r11_vec_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !call_req |-> call_vec == '0);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase_stb    (phase_stb),
    .stack_full   (stack_full),
    .pin_is_input (pin_is_input),
    .edge_mode    (edge_mode),
    .src_en       (src_en),
    .call_req     (call_req),
    .call_vec     (call_vec),
    .gie          (gie),
    .pend         (pend)
);

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phase_stb = 1'b0, stack_full = 1'b0, ext_pin = 1'b0, pin_is_input = 1'b0;
    logic [1:0] edge_mode = 2'b00;
    logic [3:0] evt_in = '0;
    logic [4:0] src_en = '0, flag_clr = '0;
    logic       gie_set = 1'b0, gie_clr = 1'b0;
    logic       call_req, gie;
    logic [7:0] call_vec;
    logic [4:0] pend;

    int    n_vec = 0, n_bad = 0;
    string cur_req = "R11";

    always #10 clk = ~clk;

    irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .phase_stb(phase_stb), .stack_full(stack_full),
        .ext_pin(ext_pin), .pin_is_input(pin_is_input), .edge_mode(edge_mode),
        .evt_in(evt_in), .src_en(src_en), .flag_clr(flag_clr),
        .gie_set(gie_set), .gie_clr(gie_clr),
        .call_req(call_req), .call_vec(call_vec), .gie(gie), .pend(pend)
    );

    // ---------------- behavioural reference model ----------------
    bit m_s1, m_s2, m_prev, m_gie, m_call;
    bit [4:0] m_flag;
    int m_vec;

    function automatic int vec_for(int i);
        int t[5] = '{4, 8, 12, 20, 24};
        return t[i];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_gie = 0; m_call = 0; m_flag = '0; m_vec = 0;
        end else begin
            bit r, f, hit;
            int pick;
            r = m_s2 && !m_prev;
            f = !m_s2 && m_prev;
            hit = pin_is_input && ((edge_mode == 2'b01 && r) || (edge_mode == 2'b10 && f) ||
                                   (edge_mode == 2'b11 && (r || f)));
            pick = -1;
            if (phase_stb && m_gie && !stack_full)
                for (int i = 0; i < 5; i++)
                    if (pick < 0 && m_flag[i] && src_en[i]) pick = i;
            for (int i = 0; i < 5; i++) begin
                bit s;
                s = (i == 0) ? hit : evt_in[i-1];
                m_flag[i] = (m_flag[i] && !flag_clr[i] && i != pick) || s;
            end
            if (pick >= 0) m_gie = 0;
            else if (gie_set) m_gie = 1;
            else if (gie_clr) m_gie = 0;
            m_call = (pick >= 0);
            m_vec  = (pick >= 0) ? vec_for(pick) : 0;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
        end
    end

    always @(posedge clk) begin
        #5;
        n_vec++;
        if (call_req !== m_call || call_vec !== 8'(m_vec) || gie !== m_gie || pend !== m_flag) begin
            n_bad++;
            $display("FAIL %s: call=%b vec=%h gie=%b pend=%b expected call=%b vec=%h gie=%b pend=%b",
                     cur_req, call_req, call_vec, gie, pend, m_call, 8'(m_vec), m_gie, m_flag);
        end
    end

    // ---------------- helpers ----------------
    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic strobe();
        phase_stb = 1; cyc(1); phase_stb = 0;
    endtask

    task automatic set_gie();
        gie_set = 1; cyc(1); gie_set = 0;
    endtask

    task automatic evt(logic [3:0] m);
        evt_in = m; cyc(1); evt_in = '0;
    endtask

    task automatic pin_to(logic v);
        ext_pin = v; cyc(4);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        cur_req = "R11";
        chk("R11 reset", {call_req, gie, pend, call_vec}, 0);

        // R10: event pulse sets its flag; R2: gie low blocks
        cur_req = "R10";
        src_en = 5'b11111;
        evt(4'b0001);
        chk("R10 timer0 flag", pend, 5'b00010);
        cur_req = "R2";
        strobe();
        chk("R2 gie low no call", call_req, 0);
        set_gie();
        src_en = 5'b00000;
        strobe();
        chk("R2 src disabled no call", call_req, 0);
        src_en = 5'b11111;
        cur_req = "R5";
        strobe();
        chk("R1 timer0 vector", {call_req, call_vec}, {1'b1, 8'h08});
        chk("R5 flag and gie cleared", {gie, pend}, 0);

        // R1: drain four internal flags in order
        cur_req = "R1";
        evt(4'b1111);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] ev [4] = '{8'h08, 8'h0C, 8'h14, 8'h18};
            set_gie();
            strobe();
            chk("R1 drain order", {call_req, call_vec}, {1'b1, ev[k]});
        end

        // R8 / R6 rising edge latency
        cur_req = "R8";
        pin_is_input = 1; edge_mode = 2'b01;
        ext_pin = 1;
        cyc(2);
        chk("R8 not yet", pend[0], 0);
        cyc(1);
        chk("R8 after third edge", pend[0], 1);
        cur_req = "R9";
        flag_clr = 5'b00001; cyc(1); flag_clr = '0;
        chk("R9 software clear", pend[0], 0);
        cur_req = "R6";
        pin_to(0);
        chk("R6 rise mode ignores fall", pend[0], 0);
        edge_mode = 2'b10;
        pin_to(1);
        chk("R6 fall mode ignores rise", pend[0], 0);
        pin_to(0);
        chk("R6 fall mode sets", pend[0], 1);
        flag_clr = 5'b00001; cyc(1); flag_clr = '0;
        edge_mode = 2'b11;
        pin_to(1);
        chk("R6 both mode rise", pend[0], 1);
        flag_clr = 5'b00001; cyc(1); flag_clr = '0;
        pin_to(0);
        chk("R6 both mode fall", pend[0], 1);
        flag_clr = 5'b00001; cyc(1); flag_clr = '0;
        edge_mode = 2'b00;
        pin_to(1); pin_to(0);
        chk("R6 mode off", pend[0], 0);

        // R7: pin not an input
        cur_req = "R7";
        edge_mode = 2'b11; pin_is_input = 0;
        pin_to(1); pin_to(0);
        chk("R7 non-input ignored", pend[0], 0);

        // R1: pin beats timers
        cur_req = "R1";
        pin_is_input = 1; edge_mode = 2'b01;
        evt(4'b1010);
        pin_to(1);
        set_gie();
        strobe();
        chk("R1 pin first", {call_req, call_vec}, {1'b1, 8'h04});

        // R4: stack full
        cur_req = "R4";
        set_gie();
        stack_full = 1;
        strobe();
        chk("R4 blocked", {call_req, gie, pend[2]}, 3'b011);
        stack_full = 0;
        strobe();
        chk("R4 served after release", {call_req, call_vec}, {1'b1, 8'h0C});

        // R3: no strobe no call; mid-interval request served next strobe
        cur_req = "R3";
        set_gie();
        cyc(5);
        chk("R3 no strobe", call_req, 0);
        evt(4'b0001);
        cyc(3);
        strobe();
        chk("R3 next strobe", {call_req, call_vec}, {1'b1, 8'h08});
        cyc(1);
        chk("R3 one cycle", call_req, 0);

        // R9: gie_clr blocks, set beats clear of same flag
        cur_req = "R9";
        set_gie();
        gie_clr = 1; cyc(1); gie_clr = 0;
        strobe();
        chk("R9 gie cleared blocks", {call_req, gie}, 0);
        evt_in = 4'b0100; flag_clr = 5'b01000; cyc(1); evt_in = '0; flag_clr = '0;
        chk("R9 set beats clear", pend[3], 1);
        phase_stb = 1; gie_set = 1; cyc(1); phase_stb = 0; gie_clr = 1; gie_set = 0;
        cyc(1); gie_clr = 0;
        rst_n = 0; cyc(2); rst_n = 1; cyc(1);
        cur_req = "R11";
        chk("R11 reset again", {call_req, gie, pend, call_vec}, 0);
        cyc(2);
        finish_run();
    end
endmodule